// File: doc/BRIEF.md
# Block-Buffered Flash Programming Controller

This controller sits between a processor's table-access path and an on-chip flash array. Data reach the array one 64-byte block at a time. Software first fills a 64-entry holding buffer by table writes, one byte per strobe, through a pointer that advances by itself. It then unlocks the controller with a two-byte key and sets a start bit. The controller next runs an internal programming timer. During that interval it holds a processor-stall output high. When the timer expires it commits the whole buffer to the block that the pointer's upper bits select.

Programming can only clear bits. Each array byte becomes the AND of its old value and the matching buffer byte. A buffer byte left at FFh therefore leaves its array byte unchanged, so single bytes can be patched without loading the rest of the buffer. A block erase forces a block back to FFh. A full rewrite is done as read, modify, erase, then program. The timer length is a parameter in clock cycles. Table reads through the same pointer let software verify the result.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, `cpu_stall` and `op_done` are low, every array byte reads FFh, and every holding byte is FFh.
- R2: An accepted table write (`tw_en`) stores `tw_data` in holding entry `ptr[5:0]` and then advances the full pointer by one.
- R3: A program operation sets each byte of the selected block to (old byte AND holding byte), so bits only go from 1 to 0 and FFh entries leave bytes untouched.
- R4: `op_done` is high for exactly one cycle, in the cycle after the timer expires, and `cpu_stall` falls on that same edge.
- R5: `cpu_stall` rises on the edge that accepts the start write and stays high for exactly PROG_CYCLES cycles.
- R6: An operation starts only after this exact order of register writes: KEY (address 3) = 55h, KEY = AAh, then CTRL (address 2) with start bit 4 set.
- R7: Any accepted access between the key bytes or between the second key byte and the start write, including a wrong key value, a pointer write or a table access, clears the unlock state, and a start bit that follows is ignored.
- R8: The start write is honoured only if the same byte has write-enable (bit 0) = 1, program-memory select (bit 1) = 1 and configuration select (bit 2) = 0. A start write that fails this check still uses up the unlock.
- R9: The block operated on is `ptr[ADDR_W-1:6]` as held at the start write. Pointer registers are PTR_LO (address 0) and PTR_HI (address 1, low ADDR_W-8 bits).
- R10: A start write with the erase bit (bit 3) set turns every byte of the selected block to FFh instead of programming it.
- R11: All holding bytes return to FFh when an operation completes. Bytes loaded before an unsuccessful start attempt are kept.
- R12: While `cpu_stall` is high, register writes, table writes and table reads are ignored.
- R13: An accepted table read (`tr_en`) returns the array byte at the pointer on `rd_data`, with `rd_valid` high in the next cycle, and then advances the pointer by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 PTR_LO, 1 PTR_HI, 2 CTRL, 3 KEY |
| reg_wdata | input | 8 | Register write data |
| tw_en | input | 1 | Table write strobe into holding buffer |
| tw_data | input | 8 | Table write byte |
| tr_en | input | 1 | Table read strobe from array |
| rd_data | output | 8 | Table read byte |
| rd_valid | output | 1 | Table read data valid |
| cpu_stall | output | 1 | High during the programming interval |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
A pointer that fails to advance or wraps wrongly shows up in the first table read after a load: the wrong byte appears on `rd_data` one cycle after the strobe. A stuck or leaky unlock state either raises `cpu_stall` after a broken sequence or fails to raise it after a good one, and this is visible on the edge after the start write. A commit that uses the wrong block, a wrong AND or a buffer that is not cleared stays hidden until the affected bytes are read back after `op_done`. For that reason every operation is followed by read-back of the target block and of a neighbouring block.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int unsigned BLK_BYTES = 64;
  localparam int unsigned BLK_AW    = $clog2(BLK_BYTES);

  localparam logic [1:0] RA_PTR_LO = 2'd0;
  localparam logic [1:0] RA_PTR_HI = 2'd1;
  localparam logic [1:0] RA_CTRL   = 2'd2;
  localparam logic [1:0] RA_KEY    = 2'd3;

  localparam int unsigned CB_WEN   = 0;
  localparam int unsigned CB_PSEL  = 1;
  localparam int unsigned CB_CFG   = 2;
  localparam int unsigned CB_ERASE = 3;
  localparam int unsigned CB_START = 4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [1:0] {
    UK_IDLE  = 2'd0,
    UK_HALF  = 2'd1,
    UK_ARMED = 2'd2
  } unlock_e;
endpackage

// File: rtl/fp_unlock.sv
module fp_unlock
  import flash_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  output logic       armed
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc) begin
      if (key_wr && key_val == KEY_FIRST)
        st_d = UK_HALF;
      else if (key_wr && key_val == KEY_SECOND && st_q == UK_HALF)
        st_d = UK_ARMED;
      else
        st_d = UK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UK_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UK_ARMED);
endmodule

// File: rtl/fp_hold_buf.sv
module fp_hold_buf
  import flash_prog_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [BLK_AW-1:0]              idx,
  input  logic [7:0]                     wdata,
  input  logic                           clr,
  output logic [BLK_BYTES-1:0][7:0]      hold
);
  logic [BLK_BYTES-1:0][7:0] hold_d;

  always_comb begin
    hold_d = hold;
    if (clr)
      hold_d = {BLK_BYTES{ERASED}};
    else if (we)
      hold_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= {BLK_BYTES{ERASED}};
    else        hold <= hold_d;
  end
endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import flash_prog_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 128000,
  parameter int unsigned BLK_NW      = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              erase_in,
  input  logic [BLK_NW-1:0] blk_in,
  output logic              busy,
  output logic              commit,
  output logic              erase_q,
  output logic [BLK_NW-1:0] blk_q,
  output logic              done
);
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_d, erase_d, done_d;
  logic [BLK_NW-1:0] blk_d;

  assign commit = busy && (cnt_q == '0);

  always_comb begin
    busy_d  = busy;
    cnt_d   = cnt_q;
    erase_d = erase_q;
    blk_d   = blk_q;
    done_d  = commit;
    if (!busy) begin
      if (start) begin
        busy_d  = 1'b1;
        cnt_d   = CNT_W'(PROG_CYCLES - 1);
        erase_d = erase_in;
        blk_d   = blk_in;
      end
    end else if (commit) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      erase_q <= 1'b0;
      blk_q   <= '0;
      done    <= 1'b0;
    end else begin
      busy    <= busy_d;
      cnt_q   <= cnt_d;
      erase_q <= erase_d;
      blk_q   <= blk_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/fp_array.sv
module fp_array
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic                      erase,
  input  logic [ADDR_W-BLK_AW-1:0]  blk,
  input  logic [BLK_BYTES-1:0][7:0] hold,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_data,
  output logic                      rd_valid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int i = 0; i < BLK_BYTES; i++) begin
        if (erase) mem[{blk, BLK_AW'(i)}] <= ERASED;
        else       mem[{blk, BLK_AW'(i)}] <= mem[{blk, BLK_AW'(i)}] & hold[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PROG_CYCLES = 128000
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       tw_en,
  input  logic [7:0] tw_data,
  input  logic       tr_en,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       cpu_stall,
  output logic       op_done
);
  localparam int unsigned BLK_NW = ADDR_W - BLK_AW;
  localparam int unsigned HI_W   = ADDR_W - 8;

  logic [ADDR_W-1:0]          ptr_q, ptr_d;
  logic                       busy, acc, key_wr, armed, start_req;
  logic                       commit, erase_q;
  logic [BLK_NW-1:0]          blk_q;
  logic [BLK_BYTES-1:0][7:0]  hold;

  assign acc    = !busy && (reg_wr || tw_en || tr_en);
  assign key_wr = acc && reg_wr && (reg_addr == RA_KEY);
  assign start_req = armed && acc && reg_wr && (reg_addr == RA_CTRL)
                   && reg_wdata[CB_START] && reg_wdata[CB_WEN]
                   && reg_wdata[CB_PSEL] && !reg_wdata[CB_CFG];

  always_comb begin
    ptr_d = ptr_q;
    if (acc) begin
      if (reg_wr && reg_addr == RA_PTR_LO)
        ptr_d = {ptr_q[ADDR_W-1:8], reg_wdata};
      else if (reg_wr && reg_addr == RA_PTR_HI)
        ptr_d = {reg_wdata[HI_W-1:0], ptr_q[7:0]};
      else if (!reg_wr && (tw_en || tr_en))
        ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  fp_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .key_wr  (key_wr),
    .key_val (reg_wdata),
    .armed   (armed)
  );

  fp_hold_buf u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (acc && !reg_wr && tw_en),
    .idx   (ptr_q[BLK_AW-1:0]),
    .wdata (tw_data),
    .clr   (commit),
    .hold  (hold)
  );

  fp_seq #(.PROG_CYCLES(PROG_CYCLES), .BLK_NW(BLK_NW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_req),
    .erase_in (reg_wdata[CB_ERASE]),
    .blk_in   (ptr_q[ADDR_W-1:BLK_AW]),
    .busy     (busy),
    .commit   (commit),
    .erase_q  (erase_q),
    .blk_q    (blk_q),
    .done     (op_done)
  );

  fp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .erase    (erase_q),
    .blk      (blk_q),
    .hold     (hold),
    .rd_en    (acc && !reg_wr && !tw_en && tr_en),
    .rd_addr  (ptr_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign cpu_stall = busy;
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PROG_CYCLES = 128000
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stall,
  input logic              op_done,
  input logic              tw_en,
  input logic              tr_en,
  input logic              reg_wr,
  input logic              rd_valid,
  input logic              armed,
  input logic [ADDR_W-1:0] ptr
);
  logic [31:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stall_cnt <= '0;
    else if (cpu_stall) stall_cnt <= stall_cnt + 1'b1;
    else                stall_cnt <= '0;
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  a_r4_stall_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> op_done);

  a_r5_stall_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> stall_cnt == PROG_CYCLES);

  a_r6_start_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(armed));

  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && !reg_wr && !cpu_stall) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && !tw_en && !reg_wr && !cpu_stall) |=> rd_valid);

  a_r12_no_read_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> !rd_valid);
endmodule

bind flash_page_prog flash_prog_chk #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_stall (cpu_stall),
  .op_done   (op_done),
  .tw_en     (tw_en),
  .tr_en     (tr_en),
  .reg_wr    (reg_wr),
  .rd_valid  (rd_valid),
  .armed     (armed),
  .ptr       (ptr_q)
);

// File: tb/tb_flash_page_prog.sv
`timescale 1ns/1ps
module tb_flash_page_prog;
  localparam int ADDR_W = 10;
  localparam int PCYC   = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic       clk, rst_n, reg_wr, tw_en, tr_en;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, tw_data, rd_data;
  logic       rd_valid, cpu_stall, op_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] hmodel [64];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  flash_page_prog #(.ADDR_W(ADDR_W), .PROG_CYCLES(PCYC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tw_en(tw_en), .tw_data(tw_data), .tr_en(tr_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .cpu_stall(cpu_stall), .op_done(op_done)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12/R13 unexpected read data", rd_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  logic [ADDR_W-1:0] tptr;

  task automatic set_ptr(input int a);
    reg_write(2'd0, 8'(a));
    reg_write(2'd1, 8'(a >> 8));
    tptr = ADDR_W'(a);
  endtask

  task automatic tw(input logic [7:0] d);
    @(negedge clk);
    tw_en = 1; tw_data = d;
    @(negedge clk);
    tw_en = 0;
    hmodel[tptr[5:0]] = d;
    tptr = tptr + 1'b1;
  endtask

  task automatic tr(input string tag);
    exp_q.push_back(model[tptr]);
    tag_q.push_back(tag);
    @(negedge clk);
    tr_en = 1;
    @(negedge clk);
    tr_en = 0;
    tptr = tptr + 1'b1;
  endtask

  task automatic read_block(input int base, input int n, input string tag);
    set_ptr(base);
    for (int i = 0; i < n; i++) tr(tag);
    @(negedge clk);
  endtask

  task automatic unlock();
    reg_write(2'd3, 8'h55);
    reg_write(2'd3, 8'hAA);
  endtask

  // wait for end of operation, check length and done, update model
  task automatic finish_op(input bit erase, input int blk, input bit chk_len);
    int n = 0;
    chk(cpu_stall == 1, "R5 stall raised after start", cpu_stall, 1);
    while (cpu_stall && n < 1000) begin n++; @(negedge clk); end
    if (chk_len) chk(n == PCYC, "R5 stall length", n, PCYC);
    chk(op_done == 1, "R4 done with stall fall", op_done, 1);
    @(negedge clk);
    chk(op_done == 0, "R4 done one cycle", op_done, 0);
    for (int i = 0; i < 64; i++)
      model[blk*64+i] = erase ? 8'hFF : (model[blk*64+i] & hmodel[i]);
    for (int i = 0; i < 64; i++) hmodel[i] = 8'hFF;
  endtask

  task automatic expect_no_start(input string tag);
    @(negedge clk);
    chk(cpu_stall == 0, tag, cpu_stall, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    tw_en = 0; tw_data = 0; tr_en = 0; tptr = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    for (int i = 0; i < 64; i++) hmodel[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_stall == 0, "R1 stall low after reset", cpu_stall, 0);
    chk(op_done == 0, "R1 done low after reset", op_done, 0);
    read_block(12'h040, 4, "R1 erased array");

    // R1/R11: program with untouched buffer changes nothing
    set_ptr(12'h040); unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 1, 1);
    read_block(12'h040, 4, "R1 holding reset FF");

    // R2/R3: load full block 1 and program
    set_ptr(12'h040);
    for (int i = 0; i < 64; i++) tw((i % 4 == 0) ? 8'hFF : 8'(~i));
    set_ptr(12'h040); unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 1, 1);
    read_block(12'h040, 64, "R2/R3 program block");

    // R3: attempt 0->1 with F0 pattern
    set_ptr(12'h040);
    for (int i = 0; i < 64; i++) tw(8'hF0);
    set_ptr(12'h040); unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 1, 1);
    read_block(12'h040, 64, "R3 only clears bits");

    // R11: repeat program without loading leaves block intact
    set_ptr(12'h040); unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 1, 1);
    read_block(12'h040, 64, "R11 buffer cleared after op");

    // R9: load at 0x100, start with pointer in block 3
    set_ptr(12'h100); tw(8'h12); tw(8'h34); tw(8'h56);
    set_ptr(12'h0C5); unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 3, 1);
    read_block(12'h0C0, 4, "R9 block from pointer");
    read_block(12'h100, 2, "R9 other block untouched");

    // R7: broken sequences
    set_ptr(12'h200); tw(8'h00);
    reg_write(2'd3, 8'h55); reg_write(2'd3, 8'h12); reg_write(2'd3, 8'hAA);
    reg_write(2'd2, 8'h13); expect_no_start("R7 wrong key byte");
    reg_write(2'd3, 8'h55); reg_write(2'd0, 8'h00); reg_write(2'd3, 8'hAA);
    reg_write(2'd2, 8'h13); expect_no_start("R7 access between keys");
    unlock(); reg_write(2'd1, 8'h02);
    reg_write(2'd2, 8'h13); expect_no_start("R7 access before start");
    tptr = ADDR_W'(12'h200);
    unlock(); reg_write(2'd2, 8'h13);
    finish_op(0, 8, 1);
    read_block(12'h200, 2, "R6/R11 kept byte programmed");

    // R8: preconditions
    set_ptr(12'h280); tw(8'h00); set_ptr(12'h280);
    unlock(); reg_write(2'd2, 8'h12); expect_no_start("R8 write-enable clear");
    unlock(); reg_write(2'd2, 8'h17); expect_no_start("R8 config selected");
    unlock(); reg_write(2'd2, 8'h11); expect_no_start("R8 data memory selected");
    reg_write(2'd2, 8'h13); expect_no_start("R8 unlock consumed");
    unlock(); reg_write(2'd2, 8'h03); expect_no_start("R6 start bit clear");
    read_block(12'h280, 1, "R8 no change after refused starts");

    // R10: erase block 1
    set_ptr(12'h040); unlock(); reg_write(2'd2, 8'h1B);
    for (int i = 0; i < 64; i++) hmodel[i] = 8'hFF;
    finish_op(1, 1, 1);
    read_block(12'h040, 64, "R10 erased block");
    read_block(12'h0C0, 1, "R10 neighbour kept");

    // R12: accesses while stalled are ignored
    set_ptr(12'h0C0); unlock(); reg_write(2'd2, 8'h13);
    reg_write(2'd0, 8'h00);
    @(negedge clk); tr_en = 1; @(negedge clk); tr_en = 0;
    finish_op(0, 3, 0);
    for (int i = 0; i < 3; i++) tr("R12 pointer unchanged by stalled access");
    @(negedge clk);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R13 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule